// File: doc/BRIEF.md
# Video Line-to-Buffer Packing Controller

This block takes a parallel camera stream of 32-bit words and packs it into fixed 4096-byte buffers for a downstream consumer. Words are qualified by a line-valid input, and a frame-sync input marks the vertical blanking interval. Every accepted word goes out on a buffer write port with its word address inside the current buffer.

The fill counter is not cleared when a line ends. It holds its value across the gap between lines and resumes when the line-valid input rises again, so lines of unequal length merge into completely filled buffers. When the 1024th word of a buffer is written, the buffer is committed as full and the counter wraps to zero. If the consumer is not ready, the controller stalls until it is. When frame sync asserts, the controller closes the frame: it emits a frame-end pulse and commits any partly filled buffer with its true byte length.

Top module: `video_line_packer`

## Requirements
- R1: After reset no word is written, even with line-valid high, until frame sync has been seen high and then low again.
- R2: Each clock edge at which line-valid is high, frame sync is low and the controller is capturing produces one write on the next cycle. The write carries the input word and an address equal to the count of words already in the buffer.
- R3: The fill counter keeps its value while line-valid is low between lines. The next line continues at the following address, so separate lines merge into one buffer.
- R4: The write of word address 1023 comes with a one-cycle commit pulse reporting 4096 bytes. The next accepted word goes to address 0.
- R5: After a full commit, words that arrive while buffer-ready is low are not written and set a sticky overflow flag, which stays high until reset. Once buffer-ready is high, capture resumes at address 0.
- R6: Frame sync rising while a frame is open gives a one-cycle frame-end pulse. If the held word count N is non-zero, a commit of 4*N bytes comes in the same cycle. If N is zero, no commit is issued.
- R7: Line-valid is ignored while frame sync is high and during blanking. The next frame starts at address 0 once frame sync is low and line-valid rises.
- R8: Synchronous reset clears the overflow flag, the counter, all outputs and the controller state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_data | input | 32 | Camera data word |
| pix_line | input | 1 | Line-valid qualifier |
| pix_frame | input | 1 | Frame sync, high during vertical blanking |
| buf_ready | input | 1 | Consumer can accept a new buffer |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 10 | Word address inside the buffer |
| wr_data | output | 32 | Word being written |
| commit_valid | output | 1 | One-cycle buffer commit pulse |
| commit_bytes | output | 13 | Byte length of the committed buffer |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| overflow | output | 1 | Sticky flag for words dropped during a stall |

## Verification
The hardest case to reach is the boundary where a buffer fills at word 1024. Getting there requires over a thousand accepted words, and the rest of the stall, merge and zero-count frame-close behaviour hangs on that boundary. The bench reaches it with directed runs of line-valid. One run fills a buffer with a single long line. Another splits 1024 words into lines of 600 and 424 with a gap between them, so the full commit must land on the last word of the second line. Buffer-ready is then held low right after a wrap to produce the stall and the overflow flag. Frame sync is raised while the counter sits at zero in the full-wait state to check the frame-end pulse with no commit.

// File: rtl/vpk_pkg.sv
package vpk_pkg;
  typedef enum logic [2:0] {
    ST_SYNC,     // waiting for frame sync to assert
    ST_VBLANK,   // frame sync high, waiting for it to drop
    ST_ARMED,    // fresh buffer, waiting for line-valid
    ST_CAPTURE,  // taking words
    ST_PARTIAL,  // line ended before the buffer filled
    ST_FULL      // buffer committed, waiting for consumer
  } vpk_state_e;

  function automatic int unsigned words_to_bytes(input int unsigned words,
                                                 input int unsigned bytes_per_word);
    return words * bytes_per_word;
  endfunction
endpackage

// File: rtl/vpk_fill_counter.sv
module vpk_fill_counter #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              clear,
  output logic [ADDR_W-1:0] count,
  output logic              at_limit
);
  localparam logic [ADDR_W-1:0] LIMIT = {ADDR_W{1'b1}};

  assign at_limit = (count == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (advance) begin
      count <= at_limit ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/vpk_ctrl_fsm.sv
module vpk_ctrl_fsm
  import vpk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       href,
  input  logic       vsync,
  input  logic       buf_ready,
  input  logic       at_limit,
  output vpk_state_e state,
  output logic       accept,
  output logic       wrap_evt,
  output logic       close_evt,
  output logic       stall_evt
);
  vpk_state_e nxt;
  logic       in_frame;
  logic       taking;

  assign in_frame  = state inside {ST_ARMED, ST_CAPTURE, ST_PARTIAL, ST_FULL};
  assign taking    = state inside {ST_ARMED, ST_CAPTURE, ST_PARTIAL};
  assign accept    = !vsync && href && (taking || (state == ST_FULL && buf_ready));
  assign wrap_evt  = accept && at_limit;
  assign close_evt = vsync && in_frame;
  assign stall_evt = !vsync && href && (state == ST_FULL) && !buf_ready;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_SYNC:   if (vsync) nxt = ST_VBLANK;
      ST_VBLANK: if (!vsync) nxt = ST_ARMED;
      default: begin
        if (vsync)                                  nxt = ST_VBLANK;
        else if (wrap_evt)                          nxt = ST_FULL;
        else if (accept)                            nxt = ST_CAPTURE;
        else if (state == ST_CAPTURE)               nxt = ST_PARTIAL;
        else if (state == ST_FULL && buf_ready)     nxt = ST_ARMED;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SYNC;
    else     state <= nxt;
  end
endmodule

// File: rtl/vpk_out_stage.sv
module vpk_out_stage
  import vpk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int BC_W   = 13,
  parameter int BPW    = 4,
  parameter int WORDS  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              wrap_evt,
  input  logic              close_evt,
  input  logic              stall_evt,
  input  logic [ADDR_W-1:0] count,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit_valid,
  output logic [BC_W-1:0]   commit_bytes,
  output logic              frame_end,
  output logic              overflow
);
  localparam logic [BC_W-1:0] FULL_BYTES = BC_W'(words_to_bytes(WORDS, BPW));

  logic            short_commit;
  logic [BC_W-1:0] short_bytes;

  assign short_commit = close_evt && (count != '0);
  assign short_bytes  = BC_W'(words_to_bytes(int'(count), BPW));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en        <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      commit_valid <= 1'b0;
      commit_bytes <= '0;
      frame_end    <= 1'b0;
      overflow     <= 1'b0;
    end else begin
      wr_en <= accept;
      if (accept) begin
        wr_addr <= count;
        wr_data <= data_in;
      end
      commit_valid <= wrap_evt || short_commit;
      commit_bytes <= wrap_evt ? FULL_BYTES : (short_commit ? short_bytes : '0);
      frame_end    <= close_evt;
      overflow     <= overflow || stall_evt;
    end
  end
endmodule

// File: rtl/video_line_packer.sv
module video_line_packer
  import vpk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_BYTES = 4096,
  localparam int BPW      = DATA_W / 8,
  localparam int WORDS    = BUF_BYTES / BPW,
  localparam int ADDR_W   = $clog2(WORDS),
  localparam int BC_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_line,
  input  logic              pix_frame,
  input  logic              buf_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit_valid,
  output logic [BC_W-1:0]   commit_bytes,
  output logic              frame_end,
  output logic              overflow
);
  vpk_state_e        state;
  logic              accept;
  logic              wrap_evt;
  logic              close_evt;
  logic              stall_evt;
  logic              at_limit;
  logic [ADDR_W-1:0] count;

  vpk_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .href      (pix_line),
    .vsync     (pix_frame),
    .buf_ready (buf_ready),
    .at_limit  (at_limit),
    .state     (state),
    .accept    (accept),
    .wrap_evt  (wrap_evt),
    .close_evt (close_evt),
    .stall_evt (stall_evt)
  );

  vpk_fill_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .advance  (accept),
    .clear    (close_evt),
    .count    (count),
    .at_limit (at_limit)
  );

  vpk_out_stage #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BC_W(BC_W), .BPW(BPW), .WORDS(WORDS)
  ) u_out (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .wrap_evt     (wrap_evt),
    .close_evt    (close_evt),
    .stall_evt    (stall_evt),
    .count        (count),
    .data_in      (pix_data),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .commit_valid (commit_valid),
    .commit_bytes (commit_bytes),
    .frame_end    (frame_end),
    .overflow     (overflow)
  );
endmodule

// File: rtl/video_line_packer_chk.sv
module video_line_packer_chk
  import vpk_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int BC_W       = 13,
  parameter int FULL_BYTES = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_frame,
  input logic              buf_ready,
  input vpk_state_e        state,
  input logic              accept,
  input logic              wrap_evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              commit_valid,
  input logic [BC_W-1:0]   commit_bytes,
  input logic              frame_end,
  input logic              overflow
);
  localparam logic [BC_W-1:0] FULL_B = BC_W'(FULL_BYTES);

  a_r2_write_follows_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> wr_en);

  a_r3_addr_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && wr_addr != '0) |-> (wr_addr == $past(wr_addr) + 1'b1));

  a_r4_wrap_commits_full: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (commit_valid && commit_bytes == FULL_B && wr_addr == {ADDR_W{1'b1}}));

  a_r5_no_write_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FULL && !buf_ready) |=> !wr_en);

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r6_commit_nonzero: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> (commit_bytes != '0));

  a_r6_frame_end_not_full: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> !(commit_valid && commit_bytes == FULL_B));

  a_r7_no_write_in_sync: assert property (@(posedge clk) disable iff (rst)
    pix_frame |=> !wr_en);
endmodule

bind video_line_packer video_line_packer_chk #(
  .ADDR_W(ADDR_W), .BC_W(BC_W), .FULL_BYTES(BUF_BYTES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pix_frame    (pix_frame),
  .buf_ready    (buf_ready),
  .state        (state),
  .accept       (accept),
  .wrap_evt     (wrap_evt),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .commit_valid (commit_valid),
  .commit_bytes (commit_bytes),
  .frame_end    (frame_end),
  .overflow     (overflow)
);

// File: tb/video_line_packer_tb.sv
module video_line_packer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pix_data = '0;
  logic        pix_line = 1'b0;
  logic        pix_frame = 1'b0;
  logic        buf_ready = 1'b1;
  logic        wr_en;
  logic [9:0]  wr_addr;
  logic [31:0] wr_data;
  logic        commit_valid;
  logic [12:0] commit_bytes;
  logic        frame_end;
  logic        overflow;

  int          checks = 0;
  int          fails = 0;
  int          seq = 0;
  logic [31:0] last_data = '0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  video_line_packer u_dut (
    .clk(clk), .rst(rst), .pix_data(pix_data), .pix_line(pix_line),
    .pix_frame(pix_frame), .buf_ready(buf_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit_valid(commit_valid),
    .commit_bytes(commit_bytes), .frame_end(frame_end), .overflow(overflow)
  );

  typedef struct packed {
    logic       vs;
    logic       hr;
    logic       rdy;
    logic       we;
    logic [9:0] addr;
    logic       cv;
    logic [12:0] bytes;
    logic       fe;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b1,1'b1,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b1,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b1,1'b1, 1'b1,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b1,1'b1, 1'b1,10'd1, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b1,1'b1, 1'b1,10'd2, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b1,1'b1, 1'b1,10'd3, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b1,1'b1, 1'b1,10'd4, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b1,1'b0,1'b1, 1'b0,10'd0, 1'b1,13'd20, 1'b1},
    '{1'b1,1'b1,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b1,1'b1, 1'b1,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b1,1'b1,1'b1, 1'b0,10'd0, 1'b1,13'd4,  1'b1},
    '{1'b1,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b0,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0},
    '{1'b1,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b1},
    '{1'b0,1'b0,1'b1, 1'b0,10'd0, 1'b0,13'd0,  1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then sample just after the edge that registers them.
  task automatic step(input logic vs, input logic hr, input logic rdy);
    @(negedge clk);
    seq++;
    pix_frame = vs;
    pix_line  = hr;
    buf_ready = rdy;
    pix_data  = 32'h5A00_0000 + 32'(seq);
    last_data = pix_data;
    @(posedge clk);
    #1;
  endtask

  // Run n cycles of line-valid high; return the number of writes seen.
  task automatic run_words(input int n, input logic rdy, output int writes);
    writes = 0;
    for (int k = 0; k < n; k++) begin
      step(1'b0, 1'b1, rdy);
      if (wr_en) writes++;
    end
  endtask

  task automatic open_frame();
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset wr_en", 32'(wr_en), 0);
    chk("R8 reset commit_valid", 32'(commit_valid), 0);
    chk("R8 reset overflow", 32'(overflow), 0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: frame open, merged lines, short commits, blanking.
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].vs, VEC[i].hr, VEC[i].rdy);
      chk($sformatf("R1 R2 R7 wr_en v%0d", i), 32'(wr_en), 32'(VEC[i].we));
      if (VEC[i].we) begin
        chk($sformatf("R3 R7 wr_addr v%0d", i), 32'(wr_addr), 32'(VEC[i].addr));
        chk($sformatf("R2 wr_data v%0d", i), wr_data, last_data);
      end
      chk($sformatf("R6 commit_valid v%0d", i), 32'(commit_valid), 32'(VEC[i].cv));
      if (VEC[i].cv)
        chk($sformatf("R6 commit_bytes v%0d", i), 32'(commit_bytes), 32'(VEC[i].bytes));
      chk($sformatf("R6 frame_end v%0d", i), 32'(frame_end), 32'(VEC[i].fe));
    end

    // R4: one long line fills a whole buffer.
    run_words(1023, 1'b1, w);
    chk("R2 writes before wrap", 32'(w), 1023);
    chk("R4 no commit before limit", 32'(commit_valid), 0);
    step(1'b0, 1'b1, 1'b1);
    chk("R4 last addr", 32'(wr_addr), 1023);
    chk("R4 full commit", 32'(commit_valid), 1);
    chk("R4 full bytes", 32'(commit_bytes), 4096);
    step(1'b0, 1'b1, 1'b1);
    chk("R4 reload wr_en", 32'(wr_en), 1);
    chk("R4 reload addr", 32'(wr_addr), 0);
    chk("R4 commit one cycle", 32'(commit_valid), 0);

    // R3: 600-word and 424-word lines with a gap merge into one full buffer.
    run_words(599, 1'b1, w);
    repeat (3) step(1'b0, 1'b0, 1'b1);
    chk("R3 no commit during gap", 32'(commit_valid), 0);
    run_words(423, 1'b1, w);
    chk("R3 resume addr", 32'(wr_addr), 1022);
    step(1'b0, 1'b1, 1'b1);
    chk("R3 merged full commit", 32'(commit_valid), 1);
    chk("R3 merged addr", 32'(wr_addr), 1023);

    // R5: stall after full commit.
    step(1'b0, 1'b1, 1'b0);
    chk("R5 stalled no write", 32'(wr_en), 0);
    chk("R5 overflow set", 32'(overflow), 1);
    step(1'b0, 1'b0, 1'b0);
    chk("R5 overflow sticky", 32'(overflow), 1);
    step(1'b0, 1'b1, 1'b1);
    chk("R5 resume write", 32'(wr_en), 1);
    chk("R5 resume addr", 32'(wr_addr), 0);
    chk("R5 overflow still set", 32'(overflow), 1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R6 one-word commit", 32'(commit_bytes), 4);
    chk("R6 one-word frame_end", 32'(frame_end), 1);

    // R8: reset mid-run clears overflow.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R8 overflow cleared", 32'(overflow), 0);
    chk("R8 frame_end cleared", 32'(frame_end), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: line-valid before any frame sync is ignored.
    step(1'b0, 1'b1, 1'b1);
    chk("R1 ignored before sync", 32'(wr_en), 0);

    // R6: frame close while waiting in the full state gives no commit.
    step(1'b0, 1'b0, 1'b1);
    open_frame();
    run_words(1024, 1'b0, w);
    chk("R4 full commit with ready low", 32'(commit_valid), 1);
    step(1'b1, 1'b0, 1'b0);
    chk("R6 zero-count frame_end", 32'(frame_end), 1);
    chk("R6 zero-count no commit", 32'(commit_valid), 0);

    finish_run();
  end
endmodule